// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the stream of byte writes that a nonvolatile memory's write sequencer has already qualified. In that stream it recognises multi-byte unlock commands. From them it keeps two pieces of state: a write-protection flag and an identification-read mode. For every write it tells the sequencer one of three things. The write is part of a command. The write is real data that may go into the page buffer. Or the write must be thrown away. While identification mode is active, it also supplies the identification byte for reads at the two lowest addresses.

A command is a run of exact address/data pairs. Only the low 15 address bits are compared against the two key addresses 5555h and 2AAAh. Turning protection on and making a protected write use the same three-write prefix, and that prefix ends with A0h. The prefix opens a load window. Every write inside the window is data, until the sequencer reports that the page load has ended by pulsing `load_close`. Turning protection off and entering identification mode share a five-write prefix and differ only in the sixth data byte. Leaving identification mode takes three writes ending in F0h. A write that breaks a sequence sends the decoder back to idle. That write is then handled as plain data: it is dropped while protection is on and passed on while protection is off.

The write interface is valid/ready. `wr_ready` is held high, so the block never back-pressures. A write transfers on any cycle where `wr_valid` is high. Its classification (`wr_is_cmd`, `wr_load_ok`) is combinational and is valid in that same cycle. Both classification outputs are low when `wr_valid` is low. Reset stands in for power loss: it clears protection, identification mode and the window.

Top module: `jedec_cmd_decoder`

## Requirements
- R1: After reset `prot_on`, `id_mode` and `win_open` are 0 and `rd_id_hit` is 0 for any read address.
- R2: Key addresses are matched on `wr_addr[14:0]` only; bits 16..15 have no effect on command recognition.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h are each flagged `wr_is_cmd`=1 with `wr_load_ok`=0. The cycle after the third write, `prot_on`=1 and `win_open`=1.
- R4: While `win_open`=1, every write gives `wr_load_ok`=1 and `wr_is_cmd`=0. A `load_close` pulse makes `win_open`=0 the next cycle.
- R5: With `prot_on`=1 and `win_open`=0, a write that is not the expected next command step gives `wr_is_cmd`=0 and `wr_load_ok`=0.
- R6: With `prot_on`=0, a write that is not the expected next command step gives `wr_load_ok`=1 and `wr_is_cmd`=0.
- R7: The six writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h are flagged as commands, and `prot_on`=0 the cycle after the sixth.
- R8: The same first five writes followed by 5555h/60h set `id_mode`=1 the cycle after the sixth, and leave `prot_on` unchanged.
- R9: The writes 5555h/AAh, 2AAAh/55h, 5555h/F0h clear `id_mode` the cycle after the third.
- R10: With `id_mode`=1 and `rd_addr[16:1]`=0, `rd_id_hit`=1 and `rd_id_data` is BFh when `rd_addr[0]`=0 and 07h when `rd_addr[0]`=1. Otherwise `rd_id_hit`=0 and `rd_id_data`=00h.
- R11: A write that does not match the expected step returns the decoder to idle. A following write that would only have been the next step is not flagged as a command.
- R12: `wr_ready` is always 1, and `wr_is_cmd` and `wr_load_ok` are 0 whenever `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (also power loss) |
| wr_valid | input | 1 | Qualified byte write present |
| wr_ready | output | 1 | Always 1; block never stalls |
| wr_addr | input | 17 | Byte write address |
| wr_data | input | 8 | Byte write data |
| wr_is_cmd | output | 1 | Current write is a command byte |
| wr_load_ok | output | 1 | Current write may be loaded as data |
| load_close | input | 1 | Sequencer pulse: page load window ended |
| prot_on | output | 1 | Write protection active |
| id_mode | output | 1 | Identification mode active |
| win_open | output | 1 | Protected load window open |
| rd_addr | input | 17 | Read address |
| rd_id_hit | output | 1 | Read is served from ID bytes |
| rd_id_data | output | 8 | ID byte for the read |

## Verification
The bench sets key addresses with random upper bits. A decoder that compared all 17 bits would miss those commands and pass them on as data. It breaks sequences at every step and then sends what would have been the next step. A decoder that kept its place after a mismatch would wrongly flag that write as a command. It drives the shared five-write prefix to both endings and checks that the 60h ending leaves protection alone. A mixed-up branch would drop protection or enter ID mode on the wrong code. Random traffic runs with protection both on and off, inside and outside the load window. A wrong discard rule would then load noise under protection or lose data without it.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_X3   = 3'd3,
    ST_X4   = 3'd4,
    ST_X5   = 3'd5
  } step_t;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_ENABLE  = 3'd1,
    ACT_UNPROT  = 3'd2,
    ACT_ID_ON   = 3'd3,
    ACT_ID_OFF  = 3'd4
  } act_t;

  localparam logic [7:0] CODE_KEY_A  = 8'hAA;
  localparam logic [7:0] CODE_KEY_B  = 8'h55;
  localparam logic [7:0] CODE_ARM    = 8'hA0;
  localparam logic [7:0] CODE_EXT    = 8'h80;
  localparam logic [7:0] CODE_ID_OFF = 8'hF0;
  localparam logic [7:0] CODE_UNPROT = 8'h20;
  localparam logic [7:0] CODE_ID_ON  = 8'h60;
endpackage

// File: rtl/cseq_match.sv
module cseq_match
  import cseq_pkg::*;
#(
  parameter int CMD_AW = 15,
  parameter logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  step_t             step,
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        data,
  output logic              hit,
  output step_t             step_nxt,
  output act_t              act
);
  logic at_a, at_b;

  always_comb begin
    at_a     = (addr_lo == KEY_ADDR_A);
    at_b     = (addr_lo == KEY_ADDR_B);
    hit      = 1'b0;
    step_nxt = ST_IDLE;
    act      = ACT_NONE;
    unique case (step)
      ST_IDLE: if (at_a && data == CODE_KEY_A) begin
        hit = 1'b1; step_nxt = ST_K1;
      end
      ST_K1: if (at_b && data == CODE_KEY_B) begin
        hit = 1'b1; step_nxt = ST_K2;
      end
      ST_K2: if (at_a) begin
        if (data == CODE_ARM) begin
          hit = 1'b1; act = ACT_ENABLE;
        end else if (data == CODE_EXT) begin
          hit = 1'b1; step_nxt = ST_X3;
        end else if (data == CODE_ID_OFF) begin
          hit = 1'b1; act = ACT_ID_OFF;
        end
      end
      ST_X3: if (at_a && data == CODE_KEY_A) begin
        hit = 1'b1; step_nxt = ST_X4;
      end
      ST_X4: if (at_b && data == CODE_KEY_B) begin
        hit = 1'b1; step_nxt = ST_X5;
      end
      ST_X5: if (at_a) begin
        if (data == CODE_UNPROT) begin
          hit = 1'b1; act = ACT_UNPROT;
        end else if (data == CODE_ID_ON) begin
          hit = 1'b1; act = ACT_ID_ON;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cseq_state.sv
module cseq_state
  import cseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  hit,
  input  step_t step_nxt,
  input  act_t  act,
  input  logic  load_close,
  output step_t step,
  output logic  prot_q,
  output logic  id_q,
  output logic  win_q
);
  logic seq_live;

  assign seq_live = take && !win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      prot_q <= 1'b0;
      id_q   <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      if (seq_live) begin
        step <= hit ? step_nxt : ST_IDLE;
        if (hit) begin
          unique case (act)
            ACT_ENABLE: begin prot_q <= 1'b1; win_q <= 1'b1; end
            ACT_UNPROT: prot_q <= 1'b0;
            ACT_ID_ON:  id_q   <= 1'b1;
            ACT_ID_OFF: id_q   <= 1'b0;
            default: ;
          endcase
        end
      end
      if (load_close && win_q) win_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cseq_id_rd.sv
module cseq_id_rd #(
  parameter int ADDR_W = 17,
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'h07
) (
  input  logic              id_q,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit,
  output logic [7:0]        data
);
  localparam int HI_W = ADDR_W - 1;

  always_comb begin
    hit  = id_q && (rd_addr[ADDR_W-1:1] == {HI_W{1'b0}});
    data = 8'h00;
    if (hit) data = rd_addr[0] ? DEV_CODE : MFR_CODE;
  end
endmodule

// File: rtl/jedec_cmd_decoder.sv
module jedec_cmd_decoder
  import cseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMD_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wr_is_cmd,
  output logic              wr_load_ok,
  input  logic              load_close,
  output logic              prot_on,
  output logic              id_mode,
  output logic              win_open,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_id_hit,
  output logic [7:0]        rd_id_data
);
  step_t step, step_nxt;
  act_t  act;
  logic  hit, take;

  assign wr_ready = 1'b1;
  assign take     = wr_valid && wr_ready;

  cseq_match #(.CMD_AW(CMD_AW)) u_match (
    .step     (step),
    .addr_lo  (wr_addr[CMD_AW-1:0]),
    .data     (wr_data),
    .hit      (hit),
    .step_nxt (step_nxt),
    .act      (act)
  );

  cseq_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .hit        (hit),
    .step_nxt   (step_nxt),
    .act        (act),
    .load_close (load_close),
    .step       (step),
    .prot_q     (prot_on),
    .id_q       (id_mode),
    .win_q      (win_open)
  );

  cseq_id_rd #(.ADDR_W(ADDR_W)) u_idrd (
    .id_q    (id_mode),
    .rd_addr (rd_addr),
    .hit     (rd_id_hit),
    .data    (rd_id_data)
  );

  always_comb begin
    wr_is_cmd  = 1'b0;
    wr_load_ok = 1'b0;
    if (take) begin
      if (win_open) begin
        wr_load_ok = 1'b1;
      end else if (hit) begin
        wr_is_cmd = 1'b1;
      end else begin
        wr_load_ok = !prot_on;
      end
    end
  end
endmodule

// File: rtl/jedec_cmd_decoder_chk.sv
module jedec_cmd_decoder_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_is_cmd,
  input logic              wr_load_ok,
  input logic              load_close,
  input logic              prot_on,
  input logic              id_mode,
  input logic              win_open,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_id_hit,
  input logic [7:0]        rd_id_data
);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (!wr_is_cmd && !wr_load_ok));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_is_cmd && wr_load_ok));

  a_r3_window_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(wr_valid && wr_is_cmd && wr_data == 8'hA0));

  a_r7_unprot_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(wr_valid && wr_is_cmd && wr_data == 8'h20));

  a_r8_id_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_valid && wr_is_cmd && wr_data == 8'h60));

  a_r9_id_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_valid && wr_is_cmd && wr_data == 8'hF0));

  a_r4_window_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && wr_valid) |-> (wr_load_ok && !wr_is_cmd));

  a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !win_open && wr_valid && !wr_is_cmd) |-> !wr_load_ok);

  a_r10_id_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id_hit |-> (id_mode && rd_addr[ADDR_W-1:1] == '0));
endmodule

bind jedec_cmd_decoder jedec_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/jedec_cmd_decoder_test.sv
module jedec_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_is_cmd, wr_load_ok;
  logic        load_close = 1'b0;
  logic        prot_on, id_mode, win_open;
  logic [16:0] rd_addr = '0;
  logic        rd_id_hit;
  logic [7:0]  rd_id_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_step = 0;
  bit m_prot = 0, m_id = 0, m_win = 0;

  always #4 clk = ~clk;

  jedec_cmd_decoder uut (.*);

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // returns 0 no match, 1 advance, 2 arm, 3 unprot, 4 id on, 5 id off
  function automatic int ref_eval(int s, logic [16:0] a, logic [7:0] d);
    logic [14:0] lo = a[14:0];
    bit ka = (lo == 15'h5555);
    bit kb = (lo == 15'h2AAA);
    case (s)
      0, 3: return (ka && d == 8'hAA) ? 1 : 0;
      1, 4: return (kb && d == 8'h55) ? 1 : 0;
      2: begin
        if (!ka) return 0;
        if (d == 8'hA0) return 2;
        if (d == 8'h80) return 1;
        if (d == 8'hF0) return 5;
        return 0;
      end
      5: begin
        if (!ka) return 0;
        if (d == 8'h20) return 3;
        if (d == 8'h60) return 4;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  task automatic check_status(string tag);
    check(tag, "prot_on", prot_on, m_prot);
    check(tag, "id_mode", id_mode, m_id);
    check(tag, "win_open", win_open, m_win);
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d, string tag);
    int r;
    bit e_cmd, e_ld;
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    #1;
    r = m_win ? 0 : ref_eval(m_step, a, d);
    e_cmd = !m_win && (r != 0);
    e_ld  = m_win || (r == 0 && !m_prot);
    check(tag, "wr_is_cmd", wr_is_cmd, e_cmd);
    check(tag, "wr_load_ok", wr_load_ok, e_ld);
    check("R12", "wr_ready", wr_ready, 1);
    @(posedge clk);
    if (!m_win) begin
      case (r)
        0: m_step = 0;
        1: m_step = m_step + 1;
        2: begin m_step = 0; m_prot = 1; m_win = 1; end
        3: begin m_step = 0; m_prot = 0; end
        4: begin m_step = 0; m_id = 1; end
        5: begin m_step = 0; m_id = 0; end
        default: m_step = 0;
      endcase
    end
    #1;
    wr_valid = 1'b0;
    check_status(tag);
  endtask

  task automatic close_win(string tag);
    @(negedge clk);
    load_close = 1'b1;
    @(posedge clk);
    m_win = 0;
    #1;
    load_close = 1'b0;
    check_status(tag);
  endtask

  task automatic rd_chk(logic [16:0] a, string tag);
    bit eh;
    @(negedge clk);
    rd_addr = a;
    #1;
    eh = m_id && (a[16:1] == 16'h0);
    check(tag, "rd_id_hit", rd_id_hit, eh);
    check(tag, "rd_id_data", rd_id_data, eh ? (a[0] ? 8'h07 : 8'hBF) : 8'h00);
  endtask

  task automatic seq_arm(logic [1:0] up, string tag);
    wr({up, 15'h5555}, 8'hAA, tag);
    wr({up, 15'h2AAA}, 8'h55, tag);
    wr({up, 15'h5555}, 8'hA0, tag);
  endtask

  task automatic seq_six(logic [7:0] last, string tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h02AAA, 8'h55, tag);
    wr(17'h05555, 8'h80, tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h02AAA, 8'h55, tag);
    wr(17'h05555, last, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_status("R1");
    rd_addr = 17'h0; #1;
    check("R1", "rd_id_hit", rd_id_hit, 0);
    rst_n = 1'b1;

    // R12: no valid, no classification
    @(negedge clk);
    wr_addr = 17'h05555; wr_data = 8'hAA; #1;
    check("R12", "wr_is_cmd idle", wr_is_cmd, 0);
    check("R12", "wr_load_ok idle", wr_load_ok, 0);

    // R6: unprotected data passes
    wr(17'h00123, 8'h3C, "R6");
    // R3 / R2: arm with upper bits set
    seq_arm(2'b11, "R2");
    // R4: window loads
    wr(17'h00200, 8'h11, "R4");
    wr(17'h05555, 8'hAA, "R4");
    close_win("R4");
    // R5: protected, discarded
    wr(17'h00300, 8'h22, "R5");
    // R11: break then next step not taken
    wr(17'h05555, 8'hAA, "R11");
    wr(17'h05555, 8'h55, "R11");
    wr(17'h02AAA, 8'h55, "R11");
    // R8: ID entry keeps protection
    seq_six(8'h60, "R8");
    rd_chk(17'h00000, "R10");
    rd_chk(17'h00001, "R10");
    rd_chk(17'h00002, "R10");
    rd_chk(17'h10000, "R10");
    // R7: unprotect
    seq_six(8'h20, "R7");
    wr(17'h00400, 8'h5A, "R6");
    // R9: ID exit
    wr(17'h05555, 8'hAA, "R9");
    wr(17'h02AAA, 8'h55, "R9");
    wr(17'h05555, 8'hF0, "R9");
    rd_chk(17'h00000, "R10");
    // R11: break at step 5 of six
    wr(17'h05555, 8'hAA, "R11");
    wr(17'h02AAA, 8'h55, "R11");
    wr(17'h05555, 8'h80, "R11");
    wr(17'h05555, 8'hAA, "R11");
    wr(17'h02AAA, 8'h54, "R11");
    wr(17'h05555, 8'h20, "R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [16:0] a;
      logic [7:0]  d;
      int k = $urandom_range(0, 99);
      string tag;
      int r;
      logic [7:0] codes [7] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'hF0, 8'h20, 8'h60};
      if (k < 3 && m_win) begin
        close_win("R4");
        continue;
      end
      if (k < 8) begin
        rd_chk(17'($urandom_range(0, 3)), "R10");
        continue;
      end
      a = 17'($urandom());
      if ($urandom_range(0, 9) < 7)
        a[14:0] = ($urandom_range(0, 1) != 0) ? 15'h5555 : 15'h2AAA;
      d = ($urandom_range(0, 9) < 8) ? codes[$urandom_range(0, 6)] : 8'($urandom());
      r = m_win ? 0 : ref_eval(m_step, a, d);
      if (m_win) tag = "R4";
      else if (r != 0) tag = "R3";
      else if (m_step != 0) tag = "R11";
      else if (m_prot) tag = "R5";
      else tag = "R6";
      wr(a, d, tag);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule